// File: doc/BRIEF.md
# Ordered Store Drain Buffer

This block sits between one core's load/store port and a shared memory port. Committed stores are queued here and written to memory later. Loads are not held behind them: a load whose address matches a queued store gets that store's data straight from the queue, and a load that matches nothing reads memory at once, even while older stores are still waiting. A store becomes visible only at the moment its write is accepted on the single memory port, so every observer sees it at the same instant.

Two drain policies are offered, selected by `pso_mode`. In strict mode (`pso_mode`=0) only the oldest queued store may be written, so memory sees the stores in enqueue order. In relaxed mode (`pso_mode`=1) the oldest store that is able to issue goes first, even when an older store to another address is still waiting. The memory side exposes a per-bank busy mask, and a store can only issue when its bank is free. A fence operation waits until every store queued before it has reached memory, and holds back every store queued after it until then. Change `pso_mode` only while the queue is empty.

Top module: `store_drain_buf`

## Requirements
- R1: After reset the queue is empty: `st_ready`=1, `ld_ready`=1, `fence_ready`=1, `mem_req_valid`=0, `ld_rsp_valid`=0, `fence_done`=0.
- R2: With `pso_mode`=0, stores are written in exactly their enqueue order. A busy bank at the oldest store stops every write.
- R3: With `pso_mode`=1, the store written is the oldest one whose bank is free, whose older same-address stores are gone, and that is not held by a fence.
- R4: Two stores to the same address are never reordered, so memory ends with the younger one's data.
- R5: A load that matches queued stores returns the youngest match's data with `ld_rsp_valid` in the cycle after acceptance, and issues no memory read.
- R6: A load that matches nothing issues a read (`mem_req_we`=0) while older stores stay queued. A read takes priority over a write in the same cycle. `ld_rsp_valid` rises the cycle after `mem_rsp_valid`.
- R7: The queue holds DEPTH (8) stores. `st_ready` is low exactly when all 8 are held.
- R8: `fence_done` pulses only after every store queued before the fence has been written. No store queued after the fence is written before that pulse.
- R9: A fence accepted while the queue is empty completes with `fence_done` in the next cycle.
- R10: A request is offered on the memory port only if bit `addr[1:0]` of `bank_busy` is 0 for its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pso_mode | input | 1 | 0: strict-order drain, 1: relaxed drain |
| st_valid | input | 1 | Store enqueue request |
| st_ready | output | 1 | Queue can accept a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Load accepted this cycle when valid |
| ld_addr | input | AW | Load address |
| ld_rsp_valid | output | 1 | Load data valid (one cycle) |
| ld_rsp_data | output | DW | Load data |
| fence_valid | input | 1 | Fence request |
| fence_ready | output | 1 | No fence in progress |
| fence_done | output | 1 | Fence complete (one cycle) |
| mem_req_valid | output | 1 | Memory request offered this cycle |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DW | Read data |
| bank_busy | input | 2**BW | Per-bank busy mask, bank = addr[BW-1:0] |

## Verification
The drain policy is tested with four queued stores under different bank-busy masks, in both modes. When the oldest store's bank is busy, the first write tells strict order apart from relaxed order. Other masks then show which younger store the relaxed picker chooses. A pattern that repeats an address checks that the younger data survives. Separate patterns cover loads that hit twice-written addresses or miss behind blocked stores, fences placed between a blocked store and a younger one, and a completely full queue. Each of these separates forwarding, read priority, fence holding and back-pressure.

// File: rtl/sdb_pkg.sv
`timescale 1ns/1ps
package sdb_pkg;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_RD   = 2'd1,
    LD_WAIT = 2'd2
  } ld_state_e;

  // occupancy after one cycle of enqueue and drain
  function automatic int unsigned occ_next(input int unsigned occ,
                                           input logic add, input logic sub);
    return occ + (add ? 32'd1 : 32'd0) - (sub ? 32'd1 : 32'd0);
  endfunction

endpackage

// File: rtl/sdb_queue.sv
`timescale 1ns/1ps
module sdb_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enq_en,
  input  logic [AW-1:0]              enq_addr,
  input  logic [DW-1:0]              enq_data,
  input  logic                       rm_en,
  input  logic [IW-1:0]              rm_idx,
  output logic [DEPTH-1:0]           q_vld,
  output logic [DEPTH-1:0][AW-1:0]   q_addr,
  output logic [DEPTH-1:0][DW-1:0]   q_data,
  output logic [CW-1:0]              q_cnt
);

  // slot 0 is the oldest; removal closes the gap, enqueue lands after survivors
  logic [CW-1:0] cnt_kept;
  assign cnt_kept = q_cnt - CW'(rm_en);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic          shift_in;
    logic          put;
    logic          nv;
    logic [AW-1:0] na;
    logic [DW-1:0] nd;
    logic          v_r;
    logic [AW-1:0] a_r;
    logic [DW-1:0] d_r;

    assign shift_in = rm_en && (IW'(i) >= rm_idx);
    assign put      = enq_en && (cnt_kept == CW'(i));

    if (i == DEPTH - 1) begin : g_last
      always_comb begin
        nv = shift_in ? 1'b0 : v_r;
        na = a_r;
        nd = d_r;
      end
    end else begin : g_inner
      always_comb begin
        nv = shift_in ? q_vld[i+1]  : v_r;
        na = shift_in ? q_addr[i+1] : a_r;
        nd = shift_in ? q_data[i+1] : d_r;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_r <= 1'b0;
        a_r <= '0;
        d_r <= '0;
      end else begin
        v_r <= nv | put;
        a_r <= put ? enq_addr : na;
        d_r <= put ? enq_data : nd;
      end
    end

    assign q_vld[i]  = v_r;
    assign q_addr[i] = a_r;
    assign q_data[i] = d_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_cnt <= '0;
    else        q_cnt <= CW'(sdb_pkg::occ_next(32'(q_cnt), enq_en, rm_en));
  end

endmodule

// File: rtl/sdb_pick.sv
`timescale 1ns/1ps
module sdb_pick #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int BW    = 2,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int IW    = $clog2(DEPTH),
  parameter int NB    = 1 << BW
) (
  input  logic                     pso,
  input  logic                     fence_on,
  input  logic [CW-1:0]            fence_cnt,
  input  logic [DEPTH-1:0]         q_vld,
  input  logic [DEPTH-1:0][AW-1:0] q_addr,
  input  logic [NB-1:0]            bank_busy,
  output logic                     pick_ok,
  output logic [IW-1:0]            pick_idx
);

  logic [DEPTH-1:0] elig;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic older_same;
      older_same = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j < i && q_vld[j] && q_addr[j] == q_addr[i]) older_same = 1'b1;
      end
      elig[i] = q_vld[i]
             && !bank_busy[q_addr[i][BW-1:0]]
             && (!fence_on || CW'(i) < fence_cnt)
             && !older_same
             && (pso || i == 0);
    end
  end

  // lowest eligible slot = oldest
  always_comb begin
    pick_ok  = 1'b0;
    pick_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pick_ok  = 1'b1;
        pick_idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/sdb_load.sv
`timescale 1ns/1ps
module sdb_load #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_fire,
  input  logic [AW-1:0]            ld_addr,
  input  logic [DEPTH-1:0]         q_vld,
  input  logic [DEPTH-1:0][AW-1:0] q_addr,
  input  logic [DEPTH-1:0][DW-1:0] q_data,
  input  logic                     rd_fire,
  input  logic                     mem_rsp_valid,
  input  logic [DW-1:0]            mem_rsp_data,
  output logic                     ld_idle,
  output logic                     fwd_hit,
  output logic                     rd_req,
  output logic [AW-1:0]            rd_addr,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_data
);
  import sdb_pkg::*;

  ld_state_e     st;
  logic [AW-1:0] a_r;
  logic [DW-1:0] fwd_data;

  // youngest match wins: later slots overwrite earlier ones
  always_comb begin
    fwd_hit  = 1'b0;
    fwd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (q_vld[i] && q_addr[i] == ld_addr) begin
        fwd_hit  = 1'b1;
        fwd_data = q_data[i];
      end
    end
  end

  assign ld_idle = (st == LD_IDLE);
  assign rd_req  = (st == LD_RD);
  assign rd_addr = a_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LD_IDLE;
      a_r       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        LD_IDLE: if (ld_fire) begin
          if (fwd_hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= fwd_data;
          end else begin
            st  <= LD_RD;
            a_r <= ld_addr;
          end
        end
        LD_RD:   if (rd_fire) st <= LD_WAIT;
        LD_WAIT: if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          rsp_data  <= mem_rsp_data;
          st        <= LD_IDLE;
        end
        default: st <= LD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/store_drain_buf.sv
`timescale 1ns/1ps
module store_drain_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int BW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pso_mode,
  input  logic                st_valid,
  output logic                st_ready,
  input  logic [AW-1:0]       st_addr,
  input  logic [DW-1:0]       st_data,
  input  logic                ld_valid,
  output logic                ld_ready,
  input  logic [AW-1:0]       ld_addr,
  output logic                ld_rsp_valid,
  output logic [DW-1:0]       ld_rsp_data,
  input  logic                fence_valid,
  output logic                fence_ready,
  output logic                fence_done,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_we,
  output logic [AW-1:0]       mem_req_addr,
  output logic [DW-1:0]       mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [DW-1:0]       mem_rsp_data,
  input  logic [(1<<BW)-1:0]  bank_busy
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  // named internal events
  logic                     enq_fire, ld_fire, rd_fire, wr_fire, fence_fire;
  logic                     rd_go, fwd_hit, rd_req, pick_ok;
  logic [AW-1:0]            rd_addr;
  logic [IW-1:0]            pick_idx;
  logic [DEPTH-1:0]         q_vld;
  logic [DEPTH-1:0][AW-1:0] q_addr;
  logic [DEPTH-1:0][DW-1:0] q_data;
  logic [CW-1:0]            q_cnt, cnt_after;
  logic                     fence_on;
  logic [CW-1:0]            fence_cnt;

  assign st_ready   = (q_cnt < CW'(DEPTH));
  assign enq_fire   = st_valid && st_ready;
  assign ld_fire    = ld_valid && ld_ready;
  assign fence_ready = !fence_on;
  assign fence_fire = fence_valid && fence_ready;
  assign fence_done = fence_on && (fence_cnt == '0);

  // memory port: a pending load read goes ahead of any drain
  assign rd_go         = rd_req && !bank_busy[rd_addr[BW-1:0]];
  assign mem_req_valid = rd_go || pick_ok;
  assign mem_req_we    = !rd_go;
  assign mem_req_addr  = rd_go ? rd_addr : q_addr[pick_idx];
  assign mem_req_wdata = rd_go ? '0 : q_data[pick_idx];
  assign rd_fire       = rd_go && mem_req_ready;
  assign wr_fire       = !rd_go && pick_ok && mem_req_ready;

  assign cnt_after = CW'(sdb_pkg::occ_next(32'(q_cnt), enq_fire, wr_fire));

  sdb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW), .IW(IW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .enq_en(enq_fire), .enq_addr(st_addr), .enq_data(st_data),
    .rm_en(wr_fire), .rm_idx(pick_idx),
    .q_vld(q_vld), .q_addr(q_addr), .q_data(q_data), .q_cnt(q_cnt)
  );

  sdb_pick #(.DEPTH(DEPTH), .AW(AW), .BW(BW), .CW(CW), .IW(IW)) u_pick (
    .pso(pso_mode), .fence_on(fence_on), .fence_cnt(fence_cnt),
    .q_vld(q_vld), .q_addr(q_addr), .bank_busy(bank_busy),
    .pick_ok(pick_ok), .pick_idx(pick_idx)
  );

  sdb_load #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_load (
    .clk(clk), .rst_n(rst_n),
    .ld_fire(ld_fire), .ld_addr(ld_addr),
    .q_vld(q_vld), .q_addr(q_addr), .q_data(q_data),
    .rd_fire(rd_fire), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .ld_idle(ld_ready), .fwd_hit(fwd_hit), .rd_req(rd_req), .rd_addr(rd_addr),
    .rsp_valid(ld_rsp_valid), .rsp_data(ld_rsp_data)
  );

  // fence: count of stores older than the fence still queued
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fence_on  <= 1'b0;
      fence_cnt <= '0;
    end else if (fence_fire) begin
      fence_on  <= 1'b1;
      fence_cnt <= cnt_after;
    end else if (fence_done) begin
      fence_on  <= 1'b0;
    end else if (fence_on && wr_fire && (CW'(pick_idx) < fence_cnt)) begin
      fence_cnt <= fence_cnt - CW'(1);
    end
  end

endmodule

// File: rtl/sdb_chk.sv
`timescale 1ns/1ps
module sdb_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int BW    = 2,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int IW    = $clog2(DEPTH)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     pso_mode,
  input logic                     wr_fire,
  input logic [IW-1:0]            pick_idx,
  input logic                     fence_on,
  input logic [CW-1:0]            fence_cnt,
  input logic [DEPTH-1:0]         q_vld,
  input logic [DEPTH-1:0][AW-1:0] q_addr,
  input logic [CW-1:0]            q_cnt,
  input logic                     mem_req_valid,
  input logic [AW-1:0]            mem_req_addr,
  input logic [(1<<BW)-1:0]       bank_busy,
  input logic                     ld_fire,
  input logic                     fwd_hit,
  input logic                     ld_rsp_valid
);

  logic older_twin;
  always_comb begin
    older_twin = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (IW'(j) < pick_idx && q_vld[j] && q_addr[j] == q_addr[pick_idx]) older_twin = 1'b1;
    end
  end

  // R2
  tso_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && !pso_mode |-> pick_idx == '0);

  // R4
  same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !older_twin);

  // R8
  fence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && fence_on |-> CW'(pick_idx) < fence_cnt);

  // R10
  bank_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !bank_busy[mem_req_addr[BW-1:0]]);

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(DEPTH));

  // R5
  fwd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire && fwd_hit |=> ld_rsp_valid);

endmodule

bind store_drain_buf sdb_chk #(.DEPTH(DEPTH), .AW(AW), .BW(BW)) u_sdb_chk (
  .clk(clk), .rst_n(rst_n), .pso_mode(pso_mode), .wr_fire(wr_fire),
  .pick_idx(pick_idx), .fence_on(fence_on), .fence_cnt(fence_cnt),
  .q_vld(q_vld), .q_addr(q_addr), .q_cnt(q_cnt),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .bank_busy(bank_busy),
  .ld_fire(ld_fire), .fwd_hit(fwd_hit), .ld_rsp_valid(ld_rsp_valid)
);

// File: tb/tb_store_drain_buf.sv
`timescale 1ns/1ps
module tb_store_drain_buf;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [15:0] NONE = 16'hFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pso_mode = 1'b0;
  logic st_valid = 1'b0, st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic ld_valid = 1'b0, ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic ld_rsp_valid;
  logic [DW-1:0] ld_rsp_data;
  logic fence_valid = 1'b0, fence_ready, fence_done;
  logic mem_req_valid, mem_req_we;
  logic mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic [3:0] bank_busy = 4'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_drain_buf dut (
    .clk(clk), .rst_n(rst_n), .pso_mode(pso_mode),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
    .fence_valid(fence_valid), .fence_ready(fence_ready), .fence_done(fence_done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .bank_busy(bank_busy)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // memory model and port monitor
  logic [31:0] mem [logic [15:0]];
  logic [15:0] wlog [0:63];
  int wn = 0, rd_cnt = 0, bank_bad = 0, fdone_cnt = 0, fdone_at = -1;
  bit rd_pend = 0;
  logic [15:0] rd_a = '0;

  always @(negedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (bank_busy[mem_req_addr[1:0]]) bank_bad++;
      if (mem_req_we) begin
        mem[mem_req_addr] = mem_req_wdata;
        if (wn < 64) wlog[wn] = mem_req_addr;
        wn++;
      end else begin
        rd_cnt++;
        rd_pend = 1;
        rd_a = mem_req_addr;
      end
    end
    if (rst_n && fence_done) begin
      fdone_cnt++;
      fdone_at = wn;
    end
  end

  always @(posedge clk) begin
    #1;
    mem_rsp_valid = rd_pend;
    mem_rsp_data  = (rd_pend && mem.exists(rd_a)) ? mem[rd_a] : 32'h0;
    rd_pend = 0;
  end

  function automatic logic [31:0] peek(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic enq(input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    st_valid = 1; st_addr = a; st_data = d;
    @(negedge clk);
    while (!st_ready) @(negedge clk);
    @(posedge clk); #1;
    st_valid = 0;
  endtask

  task automatic do_load(input logic [15:0] a, output logic [31:0] d,
                         output int lat, output int rds);
    int r0;
    r0 = rd_cnt;
    @(posedge clk); #1;
    ld_valid = 1; ld_addr = a;
    @(negedge clk);
    while (!ld_ready) @(negedge clk);
    @(posedge clk); #1;
    ld_valid = 0;
    lat = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      if (ld_rsp_valid || lat > 40) break;
    end
    d = ld_rsp_data;
    rds = rd_cnt - r0;
  endtask

  task automatic do_fence(output int lat);
    @(posedge clk); #1;
    fence_valid = 1;
    @(negedge clk);
    while (!fence_ready) @(negedge clk);
    @(posedge clk); #1;
    fence_valid = 0;
    lat = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      if (fence_done || lat > 40) break;
    end
  endtask

  task automatic fence_issue();
    @(posedge clk); #1;
    fence_valid = 1;
    @(negedge clk);
    while (!fence_ready) @(negedge clk);
    @(posedge clk); #1;
    fence_valid = 0;
  endtask

  // drain vectors: bank = addr[1:0]; four stores queued, then the first write observed
  typedef struct packed {
    logic        pso;
    logic [3:0]  mask;
    logic [3:0][15:0] a;   // a[0] is the oldest store
    logic [15:0] first;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{1'b0, 4'b0000, {16'h0043, 16'h0032, 16'h0021, 16'h0010}, 16'h0010},
    '{1'b0, 4'b0001, {16'h0043, 16'h0032, 16'h0021, 16'h0010}, NONE},
    '{1'b1, 4'b0001, {16'h0043, 16'h0032, 16'h0021, 16'h0010}, 16'h0021},
    '{1'b1, 4'b0011, {16'h0043, 16'h0032, 16'h0021, 16'h0010}, 16'h0032},
    '{1'b1, 4'b0010, {16'h0033, 16'h0010, 16'h0025, 16'h0021}, 16'h0010},
    '{1'b1, 4'b0001, {16'h0033, 16'h0020, 16'h0021, 16'h0020}, 16'h0021},
    '{1'b0, 4'b0100, {16'h0043, 16'h0032, 16'h0021, 16'h0010}, 16'h0010}
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int lat, rds;

    cycles(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(st_ready == 1 && ld_ready == 1 && fence_ready == 1, "R1", "ready flags",
        {st_ready, ld_ready, fence_ready}, 3'b111);
    chk(mem_req_valid == 0 && ld_rsp_valid == 0 && fence_done == 0, "R1", "idle outputs",
        {mem_req_valid, ld_rsp_valid, fence_done}, 0);

    // table of drain vectors (R2, R3, R4)
    for (int v = 0; v < 7; v++) begin
      vec_t t;
      logic [15:0] got;
      t = VECS[v];
      cycles(1);
      mem_req_ready = 0; bank_busy = t.mask; pso_mode = t.pso;
      for (int k = 0; k < 4; k++) enq(t.a[k], {8'(v), 8'(k), t.a[k]});
      wn = 0;
      mem_req_ready = 1;
      cycles(10);
      got = (wn > 0) ? wlog[0] : NONE;
      chk(got == t.first, t.pso ? "R3" : "R2", $sformatf("vec %0d first write", v), got, t.first);
      bank_busy = 0;
      cycles(20);
      chk(wn == 4, t.pso ? "R3" : "R2", $sformatf("vec %0d write count", v), wn, 4);
      for (int k = 0; k < 4; k++) begin
        logic [31:0] exp;
        for (int m = 0; m < 4; m++)
          if (t.a[m] == t.a[k]) exp = {8'(v), 8'(m), t.a[m]};
        chk(peek(t.a[k]) == exp, "R4", $sformatf("vec %0d final value", v), peek(t.a[k]), exp);
      end
      if (!t.pso)
        for (int k = 0; k < 4; k++)
          chk(wlog[k] == t.a[k], "R2", $sformatf("vec %0d order %0d", v, k), wlog[k], t.a[k]);
    end

    // R5 forwarding from the youngest match
    pso_mode = 0; mem_req_ready = 0; bank_busy = 0;
    enq(16'h0040, 32'h1111);
    enq(16'h0040, 32'h2222);
    enq(16'h0050, 32'h3333);
    do_load(16'h0040, d, lat, rds);
    chk(d == 32'h2222, "R5", "youngest data", d, 32'h2222);
    chk(lat == 1, "R5", "forward latency", lat, 1);
    chk(rds == 0, "R5", "no memory read", rds, 0);
    do_load(16'h0050, d, lat, rds);
    chk(d == 32'h3333, "R5", "second forward", d, 32'h3333);

    // R6 miss bypasses queued stores
    mem[16'h0061] = 32'hABCD0061;
    wn = 0;
    bank_busy = 4'b0001;
    mem_req_ready = 1;
    do_load(16'h0061, d, lat, rds);
    chk(d == 32'hABCD0061, "R6", "read data", d, 32'hABCD0061);
    chk(rds == 1, "R6", "one read", rds, 1);
    chk(lat == 3, "R6", "read latency", lat, 3);
    chk(wn == 0, "R6", "stores still queued", wn, 0);
    bank_busy = 0;
    cycles(10);
    chk(peek(16'h0040) == 32'h2222, "R4", "same-address drain", peek(16'h0040), 32'h2222);

    // R7 full queue
    mem_req_ready = 0;
    for (int k = 0; k < 7; k++) enq(16'(16'h0100 + 4 * k), 32'(k));
    @(negedge clk);
    chk(st_ready == 1, "R7", "ready with 7", st_ready, 1);
    enq(16'h011C, 32'd7);
    @(negedge clk);
    chk(st_ready == 0, "R7", "stalled with 8", st_ready, 0);
    wn = 0;
    mem_req_ready = 1;
    cycles(20);
    chk(wn == 8 && st_ready == 1, "R7", "drained", wn, 8);
    for (int k = 0; k < 8; k++)
      chk(wlog[k] == 16'(16'h0100 + 4 * k), "R2", "full-queue order", wlog[k], 16'h0100 + 4 * k);

    // R8 fence between a blocked store and a younger one
    pso_mode = 1; mem_req_ready = 0; bank_busy = 4'b0001;
    enq(16'h0080, 32'h80);
    enq(16'h0081, 32'h81);
    fence_issue();
    enq(16'h0082, 32'h82);
    wn = 0; fdone_cnt = 0; fdone_at = -1;
    mem_req_ready = 1;
    cycles(10);
    chk(wn == 1 && wlog[0] == 16'h0081, "R8", "only older free store", wlog[0], 16'h0081);
    chk(fdone_cnt == 0, "R8", "fence pending", fdone_cnt, 0);
    bank_busy = 0;
    cycles(10);
    chk(wn == 3, "R8", "all written", wn, 3);
    chk(wlog[1] == 16'h0080 && wlog[2] == 16'h0082, "R8", "post-fence order", wlog[2], 16'h0082);
    chk(fdone_cnt == 1 && fdone_at == 2, "R8", "done before younger", fdone_at, 2);

    // R9 fence on an empty queue
    do_fence(lat);
    chk(lat == 1, "R9", "empty fence latency", lat, 1);
    @(negedge clk);
    chk(fence_ready == 1, "R9", "fence released", fence_ready, 1);

    // R10 no request to a busy bank
    chk(bank_bad == 0, "R10", "busy-bank requests", bank_bad, 0);

    finish_run();
  end

endmodule